// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block sells one kind of item at a price set on an input. A coin detector sends a one-cycle strobe together with the coin's value. The controller adds each accepted coin to an 8-bit running total. When the total is not below the price, it raises a one-cycle vend pulse and starts the next sale from zero.

Inside are a four-state control machine and a small datapath. The datapath has a coin hold register, a saturating adder, the total register and an unsigned less-than comparator.

The states are:
- Init clears the total.
- Wait watches for coins and compares the total with the price.
- Add loads the sum into the total.
- Disp drives the vend pulse.

The transitions are:
- Init→Wait happens always.
- Wait→Add happens on a coin strobe.
- Wait→Disp happens when there is no coin and the total is not below the price.
- Wait→Wait happens when there is no coin and the total is below the price.
- Add→Wait happens always.
- Disp→Init happens always.

Top module: `coin_vend_ctrl`

## Requirements
- R1: An active-high synchronous reset puts the machine in Init and holds vend low. The first clock after reset is released clears the total, so coins counted before the reset do not count afterwards.
- R2: Init always moves to Wait on the next clock. While in Init the total register is loaded with zero.
- R3: In Wait, a coin strobe moves the machine to Add and captures the coin value, whatever the comparison shows. A coin that arrives in the cycle when a sale could be decided is therefore added before any vend decision.
- R4: In Wait with no coin strobe, the machine moves to Disp if the total is not below the price. Otherwise it stays in Wait.
- R5: Add loads the total plus the captured coin value, saturating at 255, and then returns to Wait. A total that overshoots the price still leads to exactly one vend.
- R6: Disp drives vend high for exactly one cycle and then moves to Init. Vend is high three clock edges after the last coin strobe that brings the total to the price.
- R7: Coin strobes that arrive while the machine is in Init, Add or Disp are ignored. They affect neither the total nor the vend timing.
- R8: The comparison is unsigned (total < price) and uses the registered total. With a price of zero, vend pulses once every three cycles without coins.
- R9: The outputs depend only on the state, which is encoded Init=00, Wait=01, Add=10, Disp=11. At most one of the clear strobe, the load strobe and vend is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| coin_stb_i | input | 1 | One-cycle coin-detected strobe |
| coin_amt_i | input | 8 | Value of the coin that comes with the strobe |
| price_i | input | 8 | Item price, unsigned |
| vend_o | output | 1 | One-cycle dispense pulse |

## Verification
Vend is the only output, so a wrong state or total shows up at the ports only as a vend pulse that is missing, early, late or repeated.

The bench predicts, for every coin sequence, the exact cycle of each vend. It checks vend in every cycle, so the following faults appear within one to three cycles:
- a wrong state code;
- a dropped Add cycle;
- a wrapped sum;
- a stray coin that was accepted.

A total that was not cleared shows up on the next sale as a vend that comes too early.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int AMT_W = 8;

    typedef enum logic [1:0] {
        ST_INIT = 2'b00,
        ST_WAIT = 2'b01,
        ST_ADD  = 2'b10,
        ST_DISP = 2'b11
    } vend_state_e;

endpackage

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic coin_stb_i,
    input  logic below_price_i,
    output logic cap_o,
    output logic vend_o,
    output logic ld_o,
    output logic clr_o
);

    vend_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_INIT;
        else       state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: state_d = ST_WAIT;
            ST_WAIT: begin
                if (coin_stb_i)          state_d = ST_ADD;
                else if (!below_price_i) state_d = ST_DISP;
                else                     state_d = ST_WAIT;
            end
            ST_ADD:  state_d = ST_WAIT;
            ST_DISP: state_d = ST_INIT;
            default: state_d = ST_INIT;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        vend_o = 1'b0;
        ld_o   = 1'b0;
        clr_o  = 1'b0;
        unique case (state_q)
            ST_INIT: clr_o  = 1'b1;
            ST_WAIT: ;
            ST_ADD:  ld_o   = 1'b1;
            ST_DISP: vend_o = 1'b1;
            default: clr_o  = 1'b1;
        endcase
    end

    // coin capture strobe for the hold register
    assign cap_o = (state_q == ST_WAIT) && coin_stb_i;

    AST_RESET_INIT: assert property (@(posedge clk_i) rst_i |=> state_q == ST_INIT); // R1
    AST_INIT_TO_WAIT: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q == ST_INIT |=> state_q == ST_WAIT); // R2
    AST_COIN_TO_ADD: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_WAIT && coin_stb_i) |=> state_q == ST_ADD); // R3
    AST_WAIT_DECIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_WAIT && !coin_stb_i && !below_price_i) |=> vend_o); // R4
    AST_ADD_TO_WAIT: assert property (@(posedge clk_i) disable iff (rst_i)
        ld_o |=> state_q == ST_WAIT); // R5
    AST_VEND_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        vend_o |=> (!vend_o && clr_o)); // R6
    AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({vend_o, ld_o, clr_o})); // R9

endmodule

// File: rtl/vend_total.sv
module vend_total #(
    parameter int AMT_W = 8
) (
    input  logic             clk_i,
    input  logic             cap_i,
    input  logic             ld_i,
    input  logic             clr_i,
    input  logic [AMT_W-1:0] coin_amt_i,
    input  logic [AMT_W-1:0] price_i,
    output logic             below_price_o
);

    localparam logic [AMT_W-1:0] SAT_MAX = {AMT_W{1'b1}};

    logic [AMT_W-1:0] hold_q;
    logic [AMT_W-1:0] total_q;
    logic [AMT_W:0]   sum_w;
    logic [AMT_W-1:0] sum_sat;

    // coin value is captured when the strobe is accepted
    always_ff @(posedge clk_i) begin
        if (cap_i) hold_q <= coin_amt_i;
    end

    assign sum_w   = {1'b0, total_q} + {1'b0, hold_q};
    assign sum_sat = sum_w[AMT_W] ? SAT_MAX : sum_w[AMT_W-1:0];

    // clear wins over load
    always_ff @(posedge clk_i) begin
        if (clr_i)     total_q <= '0;
        else if (ld_i) total_q <= sum_sat;
    end

    assign below_price_o = total_q < price_i;

    AST_CLEAR_ZERO: assert property (@(posedge clk_i)
        clr_i |=> total_q == '0); // R2
    AST_NO_WRAP: assert property (@(posedge clk_i)
        (ld_i && !clr_i && !$isunknown(total_q)) |=> total_q >= $past(total_q)); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk_i)
        (!cap_i && !$isunknown(hold_q)) |=> $stable(hold_q)); // R7

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import vend_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             coin_stb_i,
    input  logic [AMT_W-1:0] coin_amt_i,
    input  logic [AMT_W-1:0] price_i,
    output logic             vend_o
);

    logic cap_w;
    logic ld_w;
    logic clr_w;
    logic below_w;

    vend_fsm u_fsm (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .coin_stb_i    (coin_stb_i),
        .below_price_i (below_w),
        .cap_o         (cap_w),
        .vend_o        (vend_o),
        .ld_o          (ld_w),
        .clr_o         (clr_w)
    );

    vend_total #(.AMT_W(AMT_W)) u_total (
        .clk_i         (clk_i),
        .cap_i         (cap_w),
        .ld_i          (ld_w),
        .clr_i         (clr_w),
        .coin_amt_i    (coin_amt_i),
        .price_i       (price_i),
        .below_price_o (below_w)
    );

    AST_RESET_NO_VEND: assert property (@(posedge clk_i) rst_i |=> !vend_o); // R1

endmodule

// File: tb/coin_vend_ctrl_tb_top.sv
`timescale 1ns/100ps
module coin_vend_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_stb = 1'b0;
    logic [7:0] coin_amt = 8'd0;
    logic [7:0] price = 8'd100;
    logic       vend;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    mtotal = 0;
    int    exp_q[$];
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    coin_vend_ctrl dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .coin_stb_i (coin_stb),
        .coin_amt_i (coin_amt),
        .price_i    (price),
        .vend_o     (vend)
    );

    // monitor: compares vend against the expected cycle queue
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e;
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                n_bad++;
                $display("FAIL %s: vend missing at cycle %0d (actual 0, expected 1)", cur_req, exp_q[0]);
                void'(exp_q.pop_front());
            end
            e = (exp_q.size() > 0 && exp_q[0] == cyc);
            n_cmp++;
            if (vend !== e) begin
                n_bad++;
                $display("FAIL %s: cycle %0d vend actual %b expected %b", cur_req, cyc, vend, e);
            end
            if (e) void'(exp_q.pop_front());
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    initial begin
        #(5ns * 100000);
        n_bad++;
        $display("FAIL watchdog: run hung (actual running, expected done)");
        done = 1'b1;
        summary();
    end

    task automatic do_reset();
        rst = 1'b1;
        coin_stb = 1'b0;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (vend !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: vend during reset actual %b expected 0", vend);
        end
        rst = 1'b0;
        exp_q.delete();
        mtotal = 0;
        @(negedge clk); // Init -> Wait, total cleared
    endtask

    // accepted coin while in Wait; returns when back in Wait
    task automatic coin(input int v, input bit stray_in_add);
        coin_stb = 1'b1;
        coin_amt = 8'(v);
        mtotal = (mtotal + v > 255) ? 255 : mtotal + v;
        @(negedge clk);
        if (stray_in_add) begin
            coin_amt = 8'd200; // R7: strobe during Add is ignored
        end else begin
            coin_stb = 1'b0;
        end
        @(negedge clk);
        coin_stb = 1'b0;
    endtask

    // one idle cycle in Wait: sale decision
    task automatic decide(input bit stray_after);
        int m;
        m = cyc;
        if (mtotal >= int'(price)) begin
            exp_q.push_back(m + 1);
            @(negedge clk);
            if (stray_after) begin // R7: strobes in Disp and Init
                coin_stb = 1'b1;
                coin_amt = 8'd50;
            end
            @(negedge clk);
            @(negedge clk);
            coin_stb = 1'b0;
            mtotal = 0;
        end else begin
            @(negedge clk);
        end
    endtask

    initial begin
        cur_req = "R1";
        do_reset();

        cur_req = "R4";
        price = 8'd100;
        coin(30, 1'b0); decide(1'b0);
        coin(30, 1'b0); decide(1'b0);
        decide(1'b0);
        cur_req = "R6";
        coin(40, 1'b0); decide(1'b0);

        cur_req = "R5";
        coin(60, 1'b0); decide(1'b0);
        coin(70, 1'b0); decide(1'b0);
        decide(1'b0);

        cur_req = "R3";
        price = 8'd50;
        coin(50, 1'b0);
        coin(10, 1'b0);
        coin(5, 1'b0);
        decide(1'b0);
        decide(1'b0);

        cur_req = "R5";
        price = 8'd255;
        coin(200, 1'b0); decide(1'b0);
        coin(100, 1'b0); decide(1'b0);

        cur_req = "R7";
        price = 8'd20;
        coin(20, 1'b0); decide(1'b1);
        decide(1'b0);
        coin(10, 1'b1); decide(1'b0);
        coin(10, 1'b0); decide(1'b0);

        cur_req = "R8";
        price = 8'd0;
        decide(1'b0); decide(1'b0); decide(1'b0);
        price = 8'd200;
        coin(150, 1'b0); decide(1'b0);
        coin(50, 1'b0); decide(1'b0);

        cur_req = "R1";
        price = 8'd100;
        coin(90, 1'b0);
        do_reset();
        cur_req = "R2";
        coin(20, 1'b0); decide(1'b0);
        coin(80, 1'b0); decide(1'b0);
        decide(1'b0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R6: pending vends actual %0d expected 0", exp_q.size());
        end
        summary();
    end

endmodule